// File: doc/BRIEF.md
# Shifted-Operand Bitwise Inverse Unit

This block is one registered execution slice for a wide move-inverse instruction. It takes a 32-bit instruction word, the value already read from the source register that the word names, a set-flags control and the current flag nibble. It pulls the destination index, the source index, the shift kind and a split five-bit shift amount out of the word. The source value then goes through a shifter that also produces a carry-out, and the shifted value is inverted.

One clock edge after a valid input, the unit presents the inverted value, the destination index and a write enable. When flags are enabled, it also presents an updated flag nibble. A word that does not match the fixed opcode, or that names register 13 or 15, is flagged as illegal and causes neither a write nor a flag change. The register file, condition checks and program-counter writes belong to the surrounding pipeline.

Top module: `inv_shift_exec`

## Requirements
- R1: A word is accepted only when bits [31:15] equal 17'b1110_1010_0110_1111_0. Any other value there raises `illegal` with no register write and no flag change.
- R2: A word whose destination field (bits [11:8]) or source field (bits [3:0]) is 13 or 15 raises `illegal`, leaves `rd_we` and `flags_we` low, and passes `nzcv_in` unchanged to `nzcv_out`.
- R3: For an accepted word, `rd_data` is the bitwise inverse of the shifted source value, `rd_idx` is bits [11:8], and `rd_we` is high.
- R4: The shift amount is {bits[14:12], bits[7:6]} and the shift kind is bits [5:4]. Kind 00 is logical left. Amount 0 leaves the value unshifted and carries out the incoming C. Otherwise the carry-out is bit 32-n of the source.
- R5: Kind 01 is logical right. Amount 0 means a shift by 32, which gives zero with carry-out equal to source bit 31. Otherwise the carry-out is bit n-1.
- R6: Kind 10 is arithmetic right. Amount 0 means a shift by 32, which gives 32 copies of bit 31 with carry-out equal to bit 31. Otherwise the sign is replicated and the carry-out is bit n-1.
- R7: Kind 11 with a non-zero amount rotates right, with carry-out equal to bit n-1. Kind 11 with amount 0 shifts right by one, puts the incoming C into bit 31 and carries out source bit 0.
- R8: With `set_flags` high on an accepted word, N (nzcv_out[3]) is result bit 31 and Z (nzcv_out[2]) is high exactly when the 32-bit result is zero.
- R9: With `set_flags` high on an accepted word, C (nzcv_out[1]) is the shifter carry-out. V (nzcv_out[0]) always equals the V of `nzcv_in`. With `set_flags` low, `nzcv_out` equals `nzcv_in` and `flags_we` stays low.
- R10: All outputs are registered and appear on the edge after `in_valid`. Cycles without `in_valid` give low `out_valid`, `rd_we`, `flags_we` and `illegal`. An active-low reset clears these four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| in_valid | input | 1 | Instruction, operand and flags are valid this cycle |
| instr | input | 32 | Wide move-inverse instruction word |
| src_val | input | 32 | Value of the source register named in the word |
| set_flags | input | 1 | Update flags from this operation |
| nzcv_in | input | 4 | Current flags {N,Z,C,V}; C feeds the shifter |
| out_valid | output | 1 | A result from the previous cycle's input is present |
| illegal | output | 1 | The registered word was rejected |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Inverted shifted value |
| flags_we | output | 1 | Flag write enable |
| nzcv_out | output | 4 | New flags {N,Z,C,V} |

## Verification
The clocked properties assume that `in_valid`, `set_flags` and `nzcv_in` carry defined values in every cycle after reset. They also assume that reset is held across at least one clock edge before the first transaction, since the flag properties compare against the inputs of the previous cycle. The stimulus drives every input to a known value while reset is low, changes inputs only on the falling edge, and keeps `nzcv_in` defined even in idle cycles. Random words are built only with legal register indices, so that only the directed cases exercise rejection.

// File: rtl/inv_shift_pkg.sv
package inv_shift_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned AMT_W   = $clog2(WORD_W);
  localparam int unsigned FLAG_W  = 4;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    shift_kind_e      kind;
    logic [AMT_W-1:0] amt;
  } inv_fields_t;
endpackage

// File: rtl/inv_decode.sv
module inv_decode
  import inv_shift_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned SP_IDX  = 13,
  parameter int unsigned PC_IDX  = 15
) (
  input  logic [INSTR_W-1:0] instr,
  output inv_fields_t        fields,
  output logic               bad
);
  localparam int unsigned PAT_W = 17;
  localparam logic [PAT_W-1:0] FIXED_PAT = {16'hEA6F, 1'b0};

  logic pat_ok;
  logic reg_bad;

  always_comb begin
    fields.dst  = instr[11:8];
    fields.src  = instr[3:0];
    fields.kind = shift_kind_e'(instr[5:4]);
    fields.amt  = {instr[14:12], instr[7:6]};
    pat_ok      = (instr[INSTR_W-1 -: PAT_W] == FIXED_PAT);
    reg_bad     = (fields.dst == IDX_W'(SP_IDX)) || (fields.dst == IDX_W'(PC_IDX)) ||
                  (fields.src == IDX_W'(SP_IDX)) || (fields.src == IDX_W'(PC_IDX));
    bad         = !pat_ok || reg_bad;
  end
endmodule

// File: rtl/inv_shifter.sv
module inv_shifter
  import inv_shift_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  shift_kind_e   kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  y,
  output logic          cout
);
  logic [W:0]     wide_l;
  logic [W:0]     wide_r;
  logic [2*W-1:0] rot;

  always_comb begin
    wide_l = {1'b0, x} << amt;
    wide_r = {x, 1'b0} >> amt;
    rot    = {x, x} >> amt;
    y      = x;
    cout   = cin;
    unique case (kind)
      SK_LSL: begin
        if (amt != '0) begin
          y    = wide_l[W-1:0];
          cout = wide_l[W];
        end
      end
      SK_LSR: begin
        if (amt == '0) begin
          y    = '0;
          cout = x[W-1];
        end else begin
          y    = wide_r[W:1];
          cout = wide_r[0];
        end
      end
      SK_ASR: begin
        if (amt == '0) begin
          y    = {W{x[W-1]}};
          cout = x[W-1];
        end else begin
          wide_r = $unsigned($signed({x, 1'b0}) >>> amt);
          y      = wide_r[W:1];
          cout   = wide_r[0];
        end
      end
      SK_ROR: begin
        if (amt == '0) begin
          y    = {cin, x[W-1:1]};
          cout = x[0];
        end else begin
          y    = rot[W-1:0];
          cout = rot[W-1];
        end
      end
      default: begin
        y    = x;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/inv_flags.sv
module inv_flags
  import inv_shift_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0]      res,
  input  logic              shc,
  input  logic              upd,
  input  logic [FLAG_W-1:0] nzcv_in,
  output logic [FLAG_W-1:0] nzcv_next
);
  always_comb begin
    if (upd) nzcv_next = {res[W-1], ~|res, shc, nzcv_in[0]};
    else     nzcv_next = nzcv_in;
  end
endmodule

// File: rtl/inv_shift_exec.sv
module inv_shift_exec
  import inv_shift_pkg::*;
#(
  parameter int unsigned W       = WORD_W,
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [W-1:0]       src_val,
  input  logic               set_flags,
  input  logic [FLAG_W-1:0]  nzcv_in,
  output logic               out_valid,
  output logic               illegal,
  output logic               rd_we,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [W-1:0]       rd_data,
  output logic               flags_we,
  output logic [FLAG_W-1:0]  nzcv_out
);
  localparam int unsigned AW = $clog2(W);

  inv_fields_t       fields;
  logic              bad;
  logic [W-1:0]      shifted;
  logic              sh_carry;
  logic              upd;
  logic [FLAG_W-1:0] nzcv_next;

  logic              vld_d, ill_d, we_d, fwe_d;
  logic [IDX_W-1:0]  idx_d;
  logic [W-1:0]      data_d;
  logic [FLAG_W-1:0] nzcv_d;

  inv_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr (instr),
    .fields(fields),
    .bad   (bad)
  );

  inv_shifter #(.W(W), .AW(AW)) u_sh (
    .x   (src_val),
    .kind(fields.kind),
    .amt (fields.amt),
    .cin (nzcv_in[1]),
    .y   (shifted),
    .cout(sh_carry)
  );

  inv_flags #(.W(W)) u_flg (
    .res      (~shifted),
    .shc      (sh_carry),
    .upd      (upd),
    .nzcv_in  (nzcv_in),
    .nzcv_next(nzcv_next)
  );

  always_comb begin
    upd    = set_flags && !bad;
    vld_d  = in_valid;
    ill_d  = in_valid && bad;
    we_d   = in_valid && !bad;
    fwe_d  = in_valid && upd;
    idx_d  = fields.dst;
    data_d = ~shifted;
    nzcv_d = nzcv_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      rd_we     <= 1'b0;
      flags_we  <= 1'b0;
      rd_idx    <= '0;
      rd_data   <= '0;
      nzcv_out  <= '0;
    end else begin
      out_valid <= vld_d;
      illegal   <= ill_d;
      rd_we     <= we_d;
      flags_we  <= fwe_d;
      if (in_valid) begin
        rd_idx   <= idx_d;
        rd_data  <= data_d;
        nzcv_out <= nzcv_d;
      end
    end
  end

  // R2: a rejected word writes nothing and keeps the flags
  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rd_we && !flags_we && nzcv_out == $past(nzcv_in)));

  // R8: N and Z follow the registered result
  p_nflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (nzcv_out[3] == rd_data[W-1]));
  p_zflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (nzcv_out[2] == (rd_data == '0)));

  // R9: V never changes; no flag update means flags pass through
  p_vkeep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (nzcv_out[0] == $past(nzcv_in[0])));
  p_noflags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !flags_we) |-> (nzcv_out == $past(nzcv_in)));

  // R10: one-cycle latency and quiet idle cycles
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!rd_we && !flags_we && !illegal));

  // R3: a write only accompanies a legal result
  p_write_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (out_valid && !illegal));
endmodule

// File: tb/tb_inv_shift_exec.sv
module tb_inv_shift_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] src_val;
  logic        set_flags;
  logic [3:0]  nzcv_in;
  logic        out_valid, illegal, rd_we, flags_we;
  logic [3:0]  rd_idx, nzcv_out;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic        ill;
    logic        we;
    logic        fwe;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [3:0]  nz;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_shift_exec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .set_flags(set_flags), .nzcv_in(nzcv_in),
    .out_valid(out_valid), .illegal(illegal), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_data(rd_data), .flags_we(flags_we), .nzcv_out(nzcv_out)
  );

  function automatic logic [31:0] mk(input logic [3:0] rd, input logic [3:0] rm,
                                     input logic [1:0] k, input logic [4:0] n);
    return {16'hEA6F, 1'b0, n[4:2], rd, n[1:0], k, rm};
  endfunction

  // Bit-at-a-time reference shifter
  function automatic void ref_shift(input logic [31:0] x, input logic [1:0] k,
                                    input logic [4:0] n, input logic ci,
                                    output logic [31:0] y, output logic co);
    int cnt;
    cnt = ((n == 0) && (k == 2'b01 || k == 2'b10)) ? 32 : int'(n);
    y = x;
    co = ci;
    case (k)
      2'b00: for (int i = 0; i < cnt; i++) begin co = y[31]; y = {y[30:0], 1'b0}; end
      2'b01: for (int i = 0; i < cnt; i++) begin co = y[0]; y = {1'b0, y[31:1]}; end
      2'b10: for (int i = 0; i < cnt; i++) begin co = y[0]; y = {y[31], y[31:1]}; end
      default: begin
        if (n == 0) begin co = y[0]; y = {ci, y[31:1]}; end
        else for (int i = 0; i < cnt; i++) begin co = y[0]; y = {y[0], y[31:1]}; end
      end
    endcase
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] s, input logic sf,
                      input logic [3:0] f, input string tag);
    exp_t e;
    logic [31:0] sh, res;
    logic co, badr, badp;
    @(negedge clk);
    in_valid  = 1'b1;
    instr     = w;
    src_val   = s;
    set_flags = sf;
    nzcv_in   = f;
    ref_shift(s, w[5:4], {w[14:12], w[7:6]}, f[1], sh, co);
    res  = ~sh;
    badp = (w[31:15] != {16'hEA6F, 1'b0});
    badr = (w[11:8] == 4'd13) || (w[11:8] == 4'd15) || (w[3:0] == 4'd13) || (w[3:0] == 4'd15);
    e.ill  = badp || badr;
    e.we   = !e.ill;
    e.fwe  = !e.ill && sf;
    e.idx  = w[11:8];
    e.data = res;
    e.nz   = e.fwe ? {res[31], (res == 32'd0), co, f[0]} : f;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      nzcv_in  = 4'b0101;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n || done) continue;
      if (out_valid) begin
        exp_t e;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R10: unexpected out_valid, actual 1 expected 0");
        end else begin
          e = exp_q.pop_front();
          if (illegal !== e.ill || rd_we !== e.we || flags_we !== e.fwe || nzcv_out !== e.nz ||
              (e.we && (rd_idx !== e.idx || rd_data !== e.data))) begin
            n_fail++;
            $display("FAIL %s: actual ill=%b we=%b fwe=%b idx=%0d data=%h nzcv=%b expected ill=%b we=%b fwe=%b idx=%0d data=%h nzcv=%b",
                     e.tag, illegal, rd_we, flags_we, rd_idx, rd_data, nzcv_out,
                     e.ill, e.we, e.fwe, e.idx, e.data, e.nz);
          end
        end
      end else if (rd_we || flags_we || illegal) begin
        n_checks++;
        n_fail++;
        $display("FAIL R10: idle cycle actual we=%b fwe=%b ill=%b expected 0 0 0",
                 rd_we, flags_we, illegal);
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R10: watchdog expired, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_val = '0; set_flags = 1'b0; nzcv_in = '0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || rd_we !== 1'b0 || flags_we !== 1'b0 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: reset state actual v=%b we=%b fwe=%b ill=%b expected 0 0 0 0",
               out_valid, rd_we, flags_we, illegal);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4 logical left
    send(mk(4'd0, 4'd2, 2'b00, 5'd0), 32'h8000_0001, 1'b1, 4'b0010, "R4 lsl0 carry through");
    send(mk(4'd1, 4'd2, 2'b00, 5'd0), 32'h8000_0001, 1'b1, 4'b0000, "R4 lsl0 carry clear");
    send(mk(4'd3, 4'd4, 2'b00, 5'd1), 32'h8000_0001, 1'b1, 4'b0001, "R4 lsl1");
    send(mk(4'd5, 4'd6, 2'b00, 5'd31), 32'h0000_0003, 1'b1, 4'b0000, "R4 lsl31");
    // R5 logical right
    send(mk(4'd7, 4'd8, 2'b01, 5'd0), 32'h8000_0000, 1'b1, 4'b0000, "R5 lsr32");
    send(mk(4'd9, 4'd10, 2'b01, 5'd1), 32'h0000_0003, 1'b1, 4'b0000, "R5 lsr1");
    send(mk(4'd11, 4'd12, 2'b01, 5'd31), 32'hC000_0000, 1'b1, 4'b1000, "R5 lsr31");
    // R6 arithmetic right
    send(mk(4'd0, 4'd1, 2'b10, 5'd0), 32'h8000_0000, 1'b1, 4'b0000, "R6 asr32 negative");
    send(mk(4'd0, 4'd1, 2'b10, 5'd0), 32'h7FFF_FFFF, 1'b1, 4'b0010, "R6 asr32 positive");
    send(mk(4'd2, 4'd3, 2'b10, 5'd4), 32'hF000_0018, 1'b1, 4'b0000, "R6 asr4");
    // R7 rotate and extended rotate
    send(mk(4'd4, 4'd5, 2'b11, 5'd8), 32'h1234_5680, 1'b1, 4'b0000, "R7 ror8");
    send(mk(4'd6, 4'd7, 2'b11, 5'd0), 32'h0000_0001, 1'b1, 4'b0010, "R7 rrx cin1");
    send(mk(4'd6, 4'd7, 2'b11, 5'd0), 32'hFFFF_FFFE, 1'b1, 4'b0000, "R7 rrx cin0");
    // R8 zero result, R3 plain inverse
    send(mk(4'd8, 4'd9, 2'b00, 5'd0), 32'hFFFF_FFFF, 1'b1, 4'b0001, "R8 zero result");
    send(mk(4'd14, 4'd0, 2'b00, 5'd0), 32'h0F0F_00FF, 1'b1, 4'b1111, "R3 inverse to r14");
    // R9 flags untouched without set_flags
    send(mk(4'd10, 4'd11, 2'b01, 5'd3), 32'hFFFF_FFFF, 1'b0, 4'b1011, "R9 no set_flags");
    idle(1);
    // R2 reserved register indices
    send(mk(4'd13, 4'd1, 2'b00, 5'd0), 32'h1, 1'b1, 4'b0110, "R2 rd13");
    send(mk(4'd15, 4'd1, 2'b00, 5'd0), 32'h1, 1'b1, 4'b1001, "R2 rd15");
    send(mk(4'd2, 4'd13, 2'b00, 5'd0), 32'h1, 1'b1, 4'b0011, "R2 rm13");
    send(mk(4'd2, 4'd15, 2'b00, 5'd0), 32'h1, 1'b1, 4'b1100, "R2 rm15");
    // R1 opcode mismatch
    send(mk(4'd1, 4'd2, 2'b00, 5'd0) | 32'h0010_0000, 32'h5, 1'b1, 4'b0101, "R1 bit20 set");
    send(mk(4'd1, 4'd2, 2'b00, 5'd0) | 32'h0000_8000, 32'h5, 1'b1, 4'b1010, "R1 bit15 set");
    send(32'h0, 32'h5, 1'b1, 4'b0000, "R1 zero word");
    idle(3);
    // Mixed legal traffic
    for (int i = 0; i < 60; i++) begin
      logic [3:0] rd, rm;
      rd = 4'($urandom_range(0, 12));
      rm = 4'($urandom_range(0, 12));
      if (rd == 4'd12 && (i % 3) == 0) rd = 4'd14;
      send(mk(rd, rm, 2'($urandom), 5'($urandom)), $urandom, 1'($urandom),
           4'($urandom), "R3 mixed traffic");
      if ((i % 7) == 6) idle(1);
    end
    idle(4);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: pending results actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule